// File: doc/BRIEF.md
# Chained Interrupt Priority Resolver

This block chooses which of sixteen pending interrupt sources the processor takes next. Each source has a pending bit held inside the block and a 3-bit priority level assigned by software. A detection pass starts when the processor signals an op-code fetch. At that point the block takes a snapshot of the pending bits, the levels, the processor's current level and the global disable flag. A serial chain of compare stages then walks the snapshot, four stages per clock, to find the winning source.

Each stage passes its own source on only when that source is requesting and its level is strictly above the best level seen so far. The chain starts at level 0 and at source 15, and it ends at source 0. Because a stage keeps the earlier result when the levels are equal, a higher source index wins a tie. On the fourth busy cycle the winner is compared with the snapshotted processor level and the disable flag. When that check passes, the block pulses `take`, reports the source and its level, and clears the source's pending bit.

Source indices follow this fixed order, which sets the tie ranking:

| Index | Source |
| --- | --- |
| 0..2 | external pins 0..2 |
| 3..7 | timer A channels 0..4 |
| 8..10 | timer B channels 0..2 |
| 11, 12 | UART0 receive, transmit |
| 13, 14 | UART1 receive, transmit |
| 15 | A-D conversion |

Top module: `irq_chain_arbiter`

## Requirements
- R1: A `req_set` bit makes that source pending from the next cycle. The bit stays pending across any number of detections until it is accepted or cleared.
- R2: When `req_set[i]` and `req_clr[i]` are both high in the same cycle, source i is not pending afterwards.
- R3: The chain starts at level 0. A requester replaces the running best only when its level is strictly greater, so a requester at level 0 never wins.
- R4: Among requesters with equal, highest level, the one with the larger index wins (15 beats every other source, 0 loses to every other source).
- R5: A winner is accepted only when its level is strictly greater than `cpu_lvl` and `irq_dis` is 0, both taken from the snapshot.
- R6: `take` is a one-cycle pulse on the fourth busy cycle. In that same cycle `take_idx` and `take_lvl` carry the winner.
- R7: `opfetch` while `busy` is low starts a detection. `busy` is then high for exactly 4 cycles, and `opfetch` while `busy` is high has no effect.
- R8: Pending bits, levels, `cpu_lvl` and `irq_dis` are captured at the start edge. Changes made during the detection do not alter its result.
- R9: The accepted source's pending bit clears at the edge that ends the `take` cycle. A `req_set` for that source in the same cycle leaves it pending.
- R10: With no winner, or a refused winner, `take` stays low, `take_idx` and `take_lvl` are 0, and the pending bits are kept.
- R11: After reset, nothing is pending, `busy` is low and `take` is low.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_set | input | 16 | Per-source request, sets the pending bit |
| req_clr | input | 16 | Per-source software clear, wins over req_set |
| src_lvl | input | 48 | Level of source i in bits [3i+2:3i] |
| cpu_lvl | input | 3 | Current processor priority level |
| irq_dis | input | 1 | Global interrupt disable, 1 blocks acceptance |
| opfetch | input | 1 | Op-code fetch strobe that starts detection |
| take | output | 1 | Accept pulse |
| take_idx | output | 4 | Accepted source index, 0 when no accept |
| take_lvl | output | 3 | Accepted level, 0 when no accept |
| busy | output | 1 | Detection in progress |

## Verification
The bench targets these corner cases:
- Equal levels across all sixteen sources. A chain that let later stages win ties would return index 0 here instead of 15.
- Level-0 requesters. A chain that started from a nonzero value, or that compared with greater-or-equal, would accept them.
- Inputs changed during detection: levels raised, bits cleared, new requests and a new processor level. A design that read live inputs would pick a different winner.
- An op-code fetch on every cycle, which would restart or stretch the pass if busy were not honoured.
- A set and a clear in the same cycle, and a set on the accept cycle. These expose a wrong precedence in the pending register, seen as a missing or extra later accept.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;
  localparam int LVL_W = 3;
  localparam int IDX_W = 4;

  typedef struct packed {
    logic             hit;
    logic [IDX_W-1:0] idx;
    logic [LVL_W-1:0] lvl;
  } chain_t;

  // One comparator: the incoming best is replaced only on a strictly higher request.
  function automatic chain_t stage_pick(chain_t x, logic req, logic [LVL_W-1:0] y,
                                        logic [IDX_W-1:0] idx);
    chain_t z;
    z = x;
    if (req && (y > x.lvl)) begin
      z.hit = 1'b1;
      z.idx = idx;
      z.lvl = y;
    end
    return z;
  endfunction

  // Next value of the pending vector: clear wins over set, set wins over accept.
  function automatic logic [15:0] pend_next(logic [15:0] cur, logic [15:0] set,
                                            logic [15:0] clr, logic [15:0] acc);
    return ((cur & ~acc) | set) & ~clr;
  endfunction
endpackage

// File: rtl/irq_cmp_stage.sv
module irq_cmp_stage
  import irq_chain_pkg::*;
(
  input  chain_t           x_in,
  input  logic             req,
  input  logic [LVL_W-1:0] lvl,
  input  logic [IDX_W-1:0] idx,
  output chain_t           z_out
);
  assign z_out = stage_pick(x_in, req, lvl, idx);
endmodule

// File: rtl/irq_cmp_group.sv
module irq_cmp_group
  import irq_chain_pkg::*;
#(
  parameter int W = 4
) (
  input  chain_t             cin,
  input  logic [W-1:0]       req,
  input  logic [W*LVL_W-1:0] lvl,
  input  logic [IDX_W-1:0]   lo_idx,
  output chain_t             cout
);
  chain_t link [W+1];
  assign link[0] = cin;

  // Stage k looks at slice position W-1-k: the chain walks from high index to low.
  for (genvar k = 0; k < W; k++) begin : g_stage
    localparam int J = W - 1 - k;
    irq_cmp_stage u_stage (
      .x_in (link[k]),
      .req  (req[J]),
      .lvl  (lvl[J*LVL_W +: LVL_W]),
      .idx  (lo_idx + IDX_W'(J)),
      .z_out(link[k+1])
    );
  end

  assign cout = link[W];
endmodule

// File: rtl/irq_pending_reg.sv
module irq_pending_reg
  import irq_chain_pkg::*;
#(
  parameter int NSRC = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set,
  input  logic [NSRC-1:0] clr,
  input  logic [NSRC-1:0] acc_mask,
  output logic [NSRC-1:0] pend
);
  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= pend_next(pend, set, clr, acc_mask);
  end
endmodule

// File: rtl/irq_chain_arbiter.sv
module irq_chain_arbiter
  import irq_chain_pkg::*;
#(
  parameter int NSRC    = 16,
  parameter int PER_CYC = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NSRC-1:0]       req_set,
  input  logic [NSRC-1:0]       req_clr,
  input  logic [NSRC*LVL_W-1:0] src_lvl,
  input  logic [LVL_W-1:0]      cpu_lvl,
  input  logic                  irq_dis,
  input  logic                  opfetch,
  output logic                  take,
  output logic [IDX_W-1:0]      take_idx,
  output logic [LVL_W-1:0]      take_lvl,
  output logic                  busy
);
  localparam int NCYC  = NSRC / PER_CYC;
  localparam int CNT_W = (NCYC > 1) ? $clog2(NCYC) : 1;
  localparam logic [CNT_W-1:0] LAST_CYC = CNT_W'(NCYC - 1);

  logic [NSRC-1:0]       pend_q;
  logic [NSRC-1:0]       acc_mask;
  logic [NSRC-1:0]       snap_req;
  logic [NSRC*LVL_W-1:0] snap_lvl;
  logic [LVL_W-1:0]      snap_ipl;
  logic                  snap_dis;
  logic                  busy_q;
  logic [CNT_W-1:0]      cyc_q;
  chain_t                carry_q;
  chain_t                grp_out;

  // Named events for the checker and for reading the code.
  logic start_det;
  logic last_cyc;
  logic grant_ok;
  int   lo_pos;

  assign start_det = opfetch & ~busy_q;
  assign last_cyc  = busy_q & (cyc_q == LAST_CYC);
  // Cycle c covers the slice that sits c groups below the top of the source range.
  assign lo_pos    = NSRC - (int'(cyc_q) + 1) * PER_CYC;

  irq_pending_reg #(.NSRC(NSRC)) u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .set     (req_set),
    .clr     (req_clr),
    .acc_mask(acc_mask),
    .pend    (pend_q)
  );

  irq_cmp_group #(.W(PER_CYC)) u_group (
    .cin   (carry_q),
    .req   (snap_req[lo_pos +: PER_CYC]),
    .lvl   (snap_lvl[lo_pos*LVL_W +: PER_CYC*LVL_W]),
    .lo_idx(IDX_W'(lo_pos)),
    .cout  (grp_out)
  );

  assign grant_ok = last_cyc & grp_out.hit & (grp_out.lvl > snap_ipl) & ~snap_dis;

  always_comb begin
    acc_mask = '0;
    if (grant_ok) acc_mask[grp_out.idx] = 1'b1;
  end

  assign take     = grant_ok;
  assign take_idx = grant_ok ? grp_out.idx : '0;
  assign take_lvl = grant_ok ? grp_out.lvl : '0;
  assign busy     = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      cyc_q    <= '0;
      carry_q  <= '0;
      snap_req <= '0;
      snap_lvl <= '0;
      snap_ipl <= '0;
      snap_dis <= 1'b0;
    end else if (start_det) begin
      busy_q   <= 1'b1;
      cyc_q    <= '0;
      carry_q  <= '0;
      snap_req <= pend_q;
      snap_lvl <= src_lvl;
      snap_ipl <= cpu_lvl;
      snap_dis <= irq_dis;
    end else if (busy_q) begin
      carry_q <= grp_out;
      cyc_q   <= cyc_q + 1'b1;
      if (last_cyc) busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_chain_checker.sv
module irq_chain_checker
  import irq_chain_pkg::*;
#(
  parameter int NSRC = 16,
  parameter int NCYC = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             take,
  input logic [IDX_W-1:0] take_idx,
  input logic [LVL_W-1:0] take_lvl,
  input logic             opfetch,
  input logic [LVL_W-1:0] cpu_lvl,
  input logic             irq_dis,
  input logic [NSRC-1:0]  req_set,
  input logic [NSRC-1:0]  req_clr,
  input logic [NSRC-1:0]  pend_q
);
  int             run_cnt;
  logic [LVL_W-1:0] c_ipl;
  logic             c_dis;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_cnt <= 0;
      c_ipl   <= '0;
      c_dis   <= 1'b0;
    end else begin
      run_cnt <= busy ? run_cnt + 1 : 0;
      if (opfetch && !busy) begin
        c_ipl <= cpu_lvl;
        c_dis <= irq_dis;
      end
    end
  end

  AST_START_ON_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (opfetch && !busy) |=> busy);                                        // R7
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && run_cnt < NCYC - 1) |=> busy);                              // R7
  AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && run_cnt == NCYC - 1) |=> !busy);                            // R7
  AST_TAKE_LAST_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (busy && run_cnt == NCYC - 1));                             // R6
  AST_TAKE_ABOVE_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (take_lvl > c_ipl && !c_dis));                              // R5
  AST_TAKE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (take_lvl != '0));                                          // R3
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !take |-> (take_idx == '0 && take_lvl == '0));                       // R10
  AST_ACCEPT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !req_set[take_idx]) |=> !pend_q[$past(take_idx)]);          // R9
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_clr) |=> ((pend_q & $past(req_clr)) == '0));                   // R2
endmodule

bind irq_chain_arbiter irq_chain_checker #(.NSRC(NSRC), .NCYC(NCYC)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .busy    (busy),
  .take    (take),
  .take_idx(take_idx),
  .take_lvl(take_lvl),
  .opfetch (opfetch),
  .cpu_lvl (cpu_lvl),
  .irq_dis (irq_dis),
  .req_set (req_set),
  .req_clr (req_clr),
  .pend_q  (pend_q)
);

// File: tb/irq_chain_arbiter_bench.sv
module irq_chain_arbiter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] req_set = '0;
  logic [15:0] req_clr = '0;
  logic [47:0] src_lvl = '0;
  logic [2:0]  cpu_lvl = '0;
  logic        irq_dis = 1'b0;
  logic        opfetch = 1'b0;
  logic        take;
  logic [3:0]  take_idx;
  logic [2:0]  take_lvl;
  logic        busy;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  string cur_tag = "R11";

  // Bench model state
  logic [15:0] m_pend = '0;
  logic        m_busy = 1'b0;
  int          m_cnt = 0;
  logic [15:0] s_req = '0;
  logic [47:0] s_lvl = '0;
  logic [2:0]  s_ipl = '0;
  logic        s_dis = 1'b0;
  logic        e_take;
  logic [3:0]  e_idx;
  logic [2:0]  e_lvl;

  always #10 clk = ~clk;

  irq_chain_arbiter u_irq_chain_arbiter (
    .clk(clk), .rst_n(rst_n), .req_set(req_set), .req_clr(req_clr),
    .src_lvl(src_lvl), .cpu_lvl(cpu_lvl), .irq_dis(irq_dis), .opfetch(opfetch),
    .take(take), .take_idx(take_idx), .take_lvl(take_lvl), .busy(busy)
  );

  // Winner search written as a plain scan from index 15 down, strict greater wins.
  task automatic ref_pick(input logic [15:0] r, input logic [47:0] l,
                          output logic hit, output logic [3:0] idx, output logic [2:0] lv);
    hit = 1'b0; idx = '0; lv = '0;
    for (int i = 15; i >= 0; i--) begin
      if (r[i] && l[i*3 +: 3] > lv) begin
        hit = 1'b1; idx = 4'(i); lv = l[i*3 +: 3];
      end
    end
  endtask

  task automatic check(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", cur_tag, what, act, exp);
    end
  endtask

  // One clock: compare outputs at the falling edge, drive, then advance the model.
  task automatic tick(input logic [15:0] set, input logic [15:0] clr, input logic fetch,
                      input logic [47:0] lvl, input logic [2:0] ipl, input logic dis);
    logic hit;
    logic [3:0] wi;
    logic [2:0] wl;
    logic [15:0] old_pend;
    logic [15:0] acc;
    @(negedge clk);
    e_take = 1'b0; e_idx = '0; e_lvl = '0;
    if (m_busy && m_cnt == 3) begin
      ref_pick(s_req, s_lvl, hit, wi, wl);
      if (hit && wl > s_ipl && !s_dis) begin
        e_take = 1'b1; e_idx = wi; e_lvl = wl;
      end
    end
    check("busy", int'(busy), int'(m_busy));
    check("take", int'(take), int'(e_take));
    check("take_idx", int'(take_idx), int'(e_idx));
    check("take_lvl", int'(take_lvl), int'(e_lvl));
    req_set = set; req_clr = clr; opfetch = fetch;
    src_lvl = lvl; cpu_lvl = ipl; irq_dis = dis;
    @(posedge clk);
    old_pend = m_pend;
    acc = e_take ? (16'h1 << e_idx) : '0;
    m_pend = ((m_pend & ~acc) | set) & ~clr;
    if (m_busy) begin
      if (m_cnt == 3) m_busy = 1'b0;
      else m_cnt++;
    end else if (fetch) begin
      m_busy = 1'b1; m_cnt = 0;
      s_req = old_pend; s_lvl = lvl; s_ipl = ipl; s_dis = dis;
    end
  endtask

  function automatic logic [47:0] all_lvl(input logic [2:0] v);
    logic [47:0] r;
    for (int i = 0; i < 16; i++) r[i*3 +: 3] = v;
    return r;
  endfunction

  task automatic idle(input int n, input logic [47:0] lvl, input logic [2:0] ipl);
    for (int i = 0; i < n; i++) tick('0, '0, 1'b0, lvl, ipl, 1'b0);
  endtask

  task automatic detect(input logic [47:0] lvl, input logic [2:0] ipl, input logic dis);
    tick('0, '0, 1'b1, lvl, ipl, dis);
    for (int i = 0; i < 5; i++) tick('0, '0, 1'b0, lvl, ipl, dis);
  endtask

  initial begin
    logic [47:0] lv;
    void'($urandom(32'd2024));
    cur_tag = "R11";
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("reset busy", int'(busy), 0);
    check("reset take", int'(take), 0);
    rst_n = 1'b1;
    idle(2, '0, '0);
    detect('0, '0, 1'b0);  // nothing pending after reset

    // R1 and R10: refused request stays pending, taken once the CPU level drops
    cur_tag = "R10";
    lv = all_lvl(3'd2);
    tick(16'h0004, '0, 1'b0, lv, 3'd4, 1'b0);
    detect(lv, 3'd4, 1'b0);
    cur_tag = "R1";
    detect(lv, 3'd4, 1'b0);
    detect(lv, 3'd1, 1'b0);
    detect(lv, 3'd1, 1'b0);

    // R5: disable flag blocks, then allows
    cur_tag = "R5";
    lv = all_lvl(3'd6);
    tick(16'h0020, '0, 1'b0, lv, 3'd0, 1'b0);
    detect(lv, 3'd0, 1'b1);
    detect(lv, 3'd6, 1'b0);
    detect(lv, 3'd5, 1'b0);

    // R2: set and clear in one cycle
    cur_tag = "R2";
    tick(16'h0080, 16'h0080, 1'b0, lv, 3'd0, 1'b0);
    detect(lv, 3'd0, 1'b0);

    // R3: level-0 requester never wins
    cur_tag = "R3";
    tick(16'h0200, '0, 1'b0, all_lvl(3'd0), 3'd0, 1'b0);
    detect(all_lvl(3'd0), 3'd0, 1'b0);
    tick('0, 16'hFFFF, 1'b0, '0, 3'd0, 1'b0);

    // R4: all equal -> index 15; then 0 and 9 tied -> 9
    cur_tag = "R4";
    lv = all_lvl(3'd5);
    tick(16'hFFFF, '0, 1'b0, lv, 3'd0, 1'b0);
    detect(lv, 3'd0, 1'b0);
    tick('0, 16'hFFFF, 1'b0, lv, 3'd0, 1'b0);
    tick(16'h0201, '0, 1'b0, lv, 3'd0, 1'b0);
    detect(lv, 3'd0, 1'b0);
    detect(lv, 3'd0, 1'b0);

    // R8: inputs change while busy
    cur_tag = "R8";
    lv = all_lvl(3'd3);
    tick(16'h0012, '0, 1'b0, lv, 3'd2, 1'b0);
    tick('0, '0, 1'b1, lv, 3'd2, 1'b0);
    tick(16'h8000, '0, 1'b0, all_lvl(3'd7), 3'd7, 1'b1);
    tick('0, 16'h0010, 1'b0, all_lvl(3'd1), 3'd7, 1'b1);
    tick('0, '0, 1'b0, all_lvl(3'd7), 3'd0, 1'b0);
    tick('0, '0, 1'b0, all_lvl(3'd7), 3'd0, 1'b0);
    idle(2, all_lvl(3'd7), 3'd0);

    // R7: fetch on every cycle
    cur_tag = "R7";
    lv = all_lvl(3'd4);
    tick(16'h0F0F, '0, 1'b0, lv, 3'd0, 1'b0);
    for (int i = 0; i < 20; i++) tick('0, '0, 1'b1, lv, 3'd0, 1'b0);

    // R9: set on the accept cycle re-pends the same source
    cur_tag = "R9";
    tick('0, 16'hFFFF, 1'b0, lv, 3'd0, 1'b0);
    tick(16'h4000, '0, 1'b0, lv, 3'd0, 1'b0);
    tick('0, '0, 1'b1, lv, 3'd0, 1'b0);
    tick('0, '0, 1'b0, lv, 3'd0, 1'b0);
    tick('0, '0, 1'b0, lv, 3'd0, 1'b0);
    tick('0, '0, 1'b0, lv, 3'd0, 1'b0);
    tick(16'h4000, '0, 1'b0, lv, 3'd0, 1'b0);
    detect(lv, 3'd0, 1'b0);
    detect(lv, 3'd0, 1'b0);

    // R6: constrained random traffic
    cur_tag = "R6";
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] s;
      logic [15:0] c;
      logic [47:0] l;
      s = 16'($urandom) & 16'($urandom) & 16'($urandom);
      c = ($urandom_range(0, 7) == 0) ? (16'($urandom) & 16'($urandom)) : '0;
      l = {16'($urandom), 32'($urandom)};
      tick(s, c, ($urandom_range(0, 2) == 0), l, 3'($urandom_range(0, 6)),
           ($urandom_range(0, 9) == 0));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule